// File: doc/BRIEF.md
# Nibble-Tagged Parallel-Port Register Decoder

This block sits on the device side of a byte-wide host parallel-port bus. Each byte the host writes carries two things. Its upper bits hold a command tag: end of command, set write address, set read address, or plain data. Its low four bits hold either a register offset or one 4-bit value. Bit 4 chooses which half of an 8-bit location is addressed. Values come back to the host one nibble at a time on status lines. The host strobes every byte with `host_wr`, which is high for one clock.

Behind the decoder sit two stores. The first is a bank of sixteen 8-bit registers, written a nibble at a time. Offsets 0 to 5 hold the station address; the other offsets hold counts, status, masks, commands and mode. The second is a packet buffer reached through the reserved offset `BUF_OFF`. Writes to it are sequential byte writes, each sent as a low nibble and then a high nibble. Reads stream bytes back a nibble at a time. The register bank is also driven out in parallel on `reg_bank` so that the rest of the chip can read it.

The protocol state machine has seven states. IDLE means no command is active. WR_REG means a register write address is held. WR_BUF_LO means the buffer is in write mode and waiting for a high nibble. WR_BUF_HI means a buffer byte has just been committed. RD_REG means a register is selected for reading. RD_BUF_LO and RD_BUF_HI present the low or high nibble of the current buffer byte.

The transitions are as follows. An end byte returns any state to IDLE. A write-address byte moves IDLE to WR_REG, or to WR_BUF_LO when the offset is `BUF_OFF`. A read-address byte moves IDLE or any read state to RD_REG, RD_BUF_LO or RD_BUF_HI. A data byte with the high select set moves WR_BUF_LO to WR_BUF_HI and commits the byte. A data byte with the high select clear moves WR_BUF_HI back to WR_BUF_LO. In buffer read, a low-select read byte moves RD_BUF_HI to RD_BUF_LO and advances the pointer, and a high-select read byte moves RD_BUF_LO to RD_BUF_HI.

Top module: `nib_port_if`

## Requirements
- R1: After reset the machine is idle, `host_status` is 0x00 and every bit of `reg_bank` is 0.
- R2: A strobed byte whose bits 7:5 are 111 returns the machine to IDLE from any state, after which `host_status` reads 0x00.
- R3: Register write. Send a byte with bits 7:5 = 010 and the offset in bits 3:0 from IDLE, where the offset is not `BUF_OFF`. This selects that register for writing. Each following byte with bits 7:5 = 000 then writes its bits 3:0 into the register. Bit 4 = 0 selects bits 3:0 of the register and bit 4 = 1 selects bits 7:4. Further bytes with bits 7:5 = 010 do not change the selected register.
- R4: Register read. A byte with bits 7:5 = 110 selects a register for reading; bit 4 picks the half. `host_status` then equals {1'b0, nibble, 3'b000}, so the nibble sits on bits 6:3.
- R5: A byte strobed twice in a row leaves the state, the register bank and the buffer pointer as they were after the first copy.
- R6: Buffer write. A byte with bits 7:5 = 010 and offset `BUF_OFF`, sent from IDLE, enters buffer write mode with the pointer at 0. A data byte with bit 4 = 0 holds a low nibble. A following data byte with bit 4 = 1 stores {high, low} at the pointer and advances the pointer by one. Register `BUF_OFF` of the bank is never written.
- R7: Buffer read. A byte with bits 7:5 = 110 and offset `BUF_OFF`, sent from IDLE or RD_REG, sets the pointer to 0. With bit 4 = 0 the low nibble of the byte at the pointer is shown; with bit 4 = 1 the high nibble is shown. A low-select byte that follows a high-select byte first advances the pointer.
- R8: `host_status` is 0x00 in every state except RD_REG, RD_BUF_LO and RD_BUF_HI.
- R9: Several bytes are ignored. A set-read-address byte is ignored in a write state and a set-write-address byte is ignored in a read state. Bytes with bits 7:5 of 001, 011, 100 or 101 are ignored everywhere.
- R10: The buffer pointer wraps from `BUF_DEPTH`-1 to 0 in both write and read modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_data | input | 8 | Byte from the host data lines |
| host_wr | input | 1 | One-cycle strobe marking a new byte on `host_data` |
| host_status | output | 8 | Status lines; the read nibble is on bits 6:3 |
| reg_bank | output | 128 | All sixteen registers; register k is bits 8k+7:8k |

## Verification
The bench builds the block with `BUF_DEPTH` = 8 and the default `BUF_OFF` = 14. With eight entries, a run of ten buffer writes laps the pointer. Reading nine bytes back then shows that the two oldest entries were overwritten and that the read pointer also wraps to entry 0. Both of these happen within a few hundred cycles. Keeping the default buffer offset means the register-write sequences can carry value nibbles equal to 14, which shows that a second write-address byte cannot switch the machine into buffer mode.

// File: rtl/nib_pkg.sv
package nib_pkg;

    localparam int NIB_W   = 4;
    localparam int REG_CNT = 16;
    localparam int BYTE_W  = 8;

    typedef enum logic [2:0] {
        CMD_DATA,
        CMD_WADDR,
        CMD_RADDR,
        CMD_END,
        CMD_OTHER
    } cmd_e;

    typedef struct packed {
        cmd_e             cmd;
        logic             hi;
        logic [NIB_W-1:0] nib;
    } byte_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_REG,
        ST_WR_BUF_LO,
        ST_WR_BUF_HI,
        ST_RD_REG,
        ST_RD_BUF_LO,
        ST_RD_BUF_HI
    } st_e;

endpackage

// File: rtl/nib_cmd_decode.sv
module nib_cmd_decode
    import nib_pkg::*;
(
    input  logic [BYTE_W-1:0] bus_byte,
    output byte_dec_t         dec
);

    always_comb begin
        dec.hi  = bus_byte[4];
        dec.nib = bus_byte[NIB_W-1:0];
        unique case (bus_byte[7:5])
            3'b111:  dec.cmd = CMD_END;
            3'b010:  dec.cmd = CMD_WADDR;
            3'b110:  dec.cmd = CMD_RADDR;
            3'b000:  dec.cmd = CMD_DATA;
            default: dec.cmd = CMD_OTHER;
        endcase
    end

endmodule

// File: rtl/nib_reg_bank.sv
module nib_reg_bank
    import nib_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [NIB_W-1:0]        waddr,
    input  logic                    whi,
    input  logic [NIB_W-1:0]        wnib,
    input  logic [NIB_W-1:0]        raddr,
    input  logic                    rhi,
    output logic [NIB_W-1:0]        rnib,
    output logic [REG_CNT*BYTE_W-1:0] bank_flat
);

    logic [BYTE_W-1:0] regs [REG_CNT];

    for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && waddr == NIB_W'(i)) begin
                if (whi) regs[i][BYTE_W-1:NIB_W] <= wnib;
                else     regs[i][NIB_W-1:0]      <= wnib;
            end
        end
        assign bank_flat[i*BYTE_W +: BYTE_W] = regs[i];

        // R3: a nibble write touches only the selected half
        assert_lo_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
            we && waddr == NIB_W'(i) && !whi |=>
                regs[i][NIB_W-1:0] == $past(wnib) && $stable(regs[i][BYTE_W-1:NIB_W]));
        assert_hi_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
            we && waddr == NIB_W'(i) && whi |=>
                regs[i][BYTE_W-1:NIB_W] == $past(wnib) && $stable(regs[i][NIB_W-1:0]));
    end

    always_comb begin
        rnib = rhi ? regs[raddr][BYTE_W-1:NIB_W] : regs[raddr][NIB_W-1:0];
    end

endmodule

// File: rtl/nib_pkt_buf.sv
module nib_pkt_buf
    import nib_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R6: a committed byte is present at its slot on the next cycle
    logic              chk_v;
    logic [PW-1:0]     chk_a;
    logic [BYTE_W-1:0] chk_d;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_v <= 1'b0;
            chk_a <= '0;
            chk_d <= '0;
        end else begin
            chk_v <= we;
            chk_a <= waddr;
            chk_d <= wdata;
        end
    end
    assert_byte_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v |-> mem[chk_a] == chk_d);

endmodule

// File: rtl/nib_port_if.sv
module nib_port_if
    import nib_pkg::*;
#(
    parameter int BUF_DEPTH = 32,   // power of two; pointer wraps naturally
    parameter int BUF_OFF   = 14,
    localparam int PW       = $clog2(BUF_DEPTH)
)(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BYTE_W-1:0]         host_data,
    input  logic                      host_wr,
    output logic [BYTE_W-1:0]         host_status,
    output logic [REG_CNT*BYTE_W-1:0] reg_bank
);

    localparam logic [NIB_W-1:0] BUF_SEL = NIB_W'(BUF_OFF);

    byte_dec_t          dec;
    st_e                state, nxt_state;
    logic [NIB_W-1:0]   addr, nxt_addr;
    logic               rd_hi, nxt_rd_hi;
    logic [PW-1:0]      ptr, nxt_ptr;
    logic [NIB_W-1:0]   lo_hold, nxt_lo_hold;
    logic               reg_we, mem_we;
    logic [NIB_W-1:0]   reg_rnib;
    logic [BYTE_W-1:0]  mem_rdata;
    logic [NIB_W-1:0]   stat_nib;
    logic               in_read;

    nib_cmd_decode u_dec (
        .bus_byte (host_data),
        .dec      (dec)
    );

    nib_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .waddr     (addr),
        .whi       (dec.hi),
        .wnib      (dec.nib),
        .raddr     (addr),
        .rhi       (rd_hi),
        .rnib      (reg_rnib),
        .bank_flat (reg_bank)
    );

    nib_pkt_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (ptr),
        .wdata ({dec.nib, lo_hold}),
        .raddr (ptr),
        .rdata (mem_rdata)
    );

    assign in_read = (state == ST_RD_REG) || (state == ST_RD_BUF_LO) ||
                     (state == ST_RD_BUF_HI);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr    <= '0;
            rd_hi   <= 1'b0;
            ptr     <= '0;
            lo_hold <= '0;
        end else begin
            state   <= nxt_state;
            addr    <= nxt_addr;
            rd_hi   <= nxt_rd_hi;
            ptr     <= nxt_ptr;
            lo_hold <= nxt_lo_hold;
        end
    end

    // Transition logic
    always_comb begin
        nxt_state   = state;
        nxt_addr    = addr;
        nxt_rd_hi   = rd_hi;
        nxt_ptr     = ptr;
        nxt_lo_hold = lo_hold;
        reg_we      = 1'b0;
        mem_we      = 1'b0;
        if (host_wr) begin
            unique case (dec.cmd)
                CMD_END: nxt_state = ST_IDLE;
                CMD_WADDR: begin
                    if (state == ST_IDLE) begin
                        nxt_addr = dec.nib;
                        if (dec.nib == BUF_SEL) begin
                            nxt_state   = ST_WR_BUF_LO;
                            nxt_ptr     = '0;
                            nxt_lo_hold = '0;
                        end else begin
                            nxt_state = ST_WR_REG;
                        end
                    end
                end
                CMD_RADDR: begin
                    if (state == ST_IDLE || in_read) begin
                        if (dec.nib == BUF_SEL) begin
                            if (state == ST_RD_BUF_HI && !dec.hi) begin
                                nxt_state = ST_RD_BUF_LO;
                                nxt_ptr   = ptr + PW'(1);
                            end else if (state == ST_RD_BUF_LO && dec.hi) begin
                                nxt_state = ST_RD_BUF_HI;
                            end else if (state == ST_IDLE || state == ST_RD_REG) begin
                                nxt_state = dec.hi ? ST_RD_BUF_HI : ST_RD_BUF_LO;
                                nxt_ptr   = '0;
                            end
                        end else begin
                            nxt_state = ST_RD_REG;
                            nxt_addr  = dec.nib;
                            nxt_rd_hi = dec.hi;
                        end
                    end
                end
                CMD_DATA: begin
                    unique case (state)
                        ST_WR_REG: reg_we = 1'b1;
                        ST_WR_BUF_LO: begin
                            if (dec.hi) begin
                                mem_we    = 1'b1;
                                nxt_ptr   = ptr + PW'(1);
                                nxt_state = ST_WR_BUF_HI;
                            end else begin
                                nxt_lo_hold = dec.nib;
                            end
                        end
                        ST_WR_BUF_HI: begin
                            if (!dec.hi) begin
                                nxt_lo_hold = dec.nib;
                                nxt_state   = ST_WR_BUF_LO;
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Output logic
    always_comb begin
        unique case (state)
            ST_RD_REG:    stat_nib = reg_rnib;
            ST_RD_BUF_LO: stat_nib = mem_rdata[NIB_W-1:0];
            ST_RD_BUF_HI: stat_nib = mem_rdata[BYTE_W-1:NIB_W];
            default:      stat_nib = '0;
        endcase
        host_status = {1'b0, stat_nib, 3'b000};
    end

    // ---------------- assertions ----------------
    logic [BYTE_W-1:0] chk_last;
    logic              chk_last_v;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_last   <= '0;
            chk_last_v <= 1'b0;
        end else if (host_wr) begin
            chk_last   <= host_data;
            chk_last_v <= 1'b1;
        end
    end

    assert_end_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_data[7:5] == 3'b111 |=> state == ST_IDLE);

    assert_dup_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && chk_last_v && host_data == chk_last |=>
            $stable(state) && $stable(ptr) && $stable(reg_bank));

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ptr == PW'($past(ptr) + PW'(1)));

    assert_status_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_read |-> host_status == '0);

    assert_mem_only_in_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> state == ST_WR_BUF_LO);

endmodule

// File: tb/nib_port_if_bench.sv
module nib_port_if_bench;
    import nib_pkg::*;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_wr = 1'b0;
    logic [7:0] host_status;
    logic [REG_CNT*8-1:0] reg_bank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_reg [REG_CNT];

    always #5 clk = ~clk;

    nib_port_if #(.BUF_DEPTH(DEPTH), .BUF_OFF(14)) u_nib_port_if (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_data   (host_data),
        .host_wr     (host_wr),
        .host_status (host_status),
        .reg_bank    (reg_bank)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one byte; returns at the negedge after it was captured
    task automatic send(input logic [7:0] b);
        host_data = b;
        host_wr   = 1'b1;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    function automatic logic [7:0] stat_of(input logic [3:0] n);
        return {1'b0, n, 3'b000};
    endfunction

    task automatic reg_write(input logic [3:0] off, input logic [7:0] val);
        send(8'hE0 | off);
        send(8'h40 | off);
        send(8'h40 | off);
        check("R8 status quiet in write", host_status, 8'h00);
        send(8'h40 | val[3:0]);       // value-carrying address byte, no address change
        send({4'h0, val[3:0]});
        send({4'h0, val[3:0]});
        send(8'h50 | val[7:4]);
        send(8'h10 | val[7:4]);
        send(8'h10 | val[7:4]);
        send(8'hE0 | off);
        exp_reg[off] = val;
    endtask

    task automatic t_reset;
        check("R1 status after reset", host_status, 8'h00);
        check("R1 bank after reset", reg_bank, '0);
    endtask

    task automatic t_reg_write;
        reg_write(4'd3, 8'hA5);
        reg_write(4'd0, 8'hE2);
        reg_write(4'd11, 8'h7E);
        reg_write(4'd5, 8'h3C);
        for (int k = 0; k < REG_CNT; k++)
            check("R3 bank contents", reg_bank[k*8 +: 8], exp_reg[k]);
    endtask

    task automatic t_reg_read;
        send(8'hE3);
        send(8'hC3);
        check("R4 low nibble read", host_status, stat_of(4'h5));
        send(8'hD3);
        check("R4 high nibble read", host_status, stat_of(4'hA));
        send(8'hD3);
        check("R5 duplicate read byte", host_status, stat_of(4'hA));
        send(8'hCB);
        check("R4 switch register", host_status, stat_of(4'hE));
        send(8'hE3);
        check("R2 end returns status to zero", host_status, 8'h00);
    endtask

    task automatic t_ignore;
        // read-address ignored while writing
        send(8'hE5);
        send(8'h45);
        send(8'hC3);
        check("R9 read cmd ignored in write", host_status, 8'h00);
        send(8'h09);
        exp_reg[5] = {exp_reg[5][7:4], 4'h9};
        check("R9 write addr kept", reg_bank[5*8 +: 8], exp_reg[5]);
        check("R9 other reg untouched", reg_bank[3*8 +: 8], exp_reg[3]);
        send(8'hE5);
        // write-address, data and other codes ignored while reading
        send(8'hC3);
        send(8'h45);
        check("R9 write cmd ignored in read", host_status, stat_of(4'h5));
        send(8'h2F);
        check("R9 code 001 ignored", host_status, stat_of(4'h5));
        send(8'h8F);
        check("R9 code 100 ignored", host_status, stat_of(4'h5));
        send(8'h07);
        check("R9 data ignored in read", reg_bank, {exp_reg[15], exp_reg[14], exp_reg[13], exp_reg[12],
              exp_reg[11], exp_reg[10], exp_reg[9], exp_reg[8], exp_reg[7], exp_reg[6],
              exp_reg[5], exp_reg[4], exp_reg[3], exp_reg[2], exp_reg[1], exp_reg[0]});
        send(8'hE0);
        check("R2 end from read", host_status, 8'h00);
    endtask

    task automatic buf_write_byte(input logic [7:0] b);
        send({4'h0, b[3:0]});
        send({4'h0, b[3:0]});
        send(8'h10 | b[7:4]);
        send(8'h10 | b[7:4]);
    endtask

    task automatic buf_read_byte(input string req, input logic [7:0] b);
        send(8'hCE);
        check(req, host_status, stat_of(b[3:0]));
        send(8'hDE);
        check(req, host_status, stat_of(b[7:4]));
    endtask

    task automatic t_buffer;
        logic [7:0] bytes [4];
        bytes[0] = 8'h12; bytes[1] = 8'hF0; bytes[2] = 8'h9C; bytes[3] = 8'h4B;
        send(8'hEE);
        send(8'h4E);
        send(8'h4E);
        check("R8 quiet in buffer write", host_status, 8'h00);
        for (int k = 0; k < 4; k++) buf_write_byte(bytes[k]);
        send(8'hEE);
        check("R6 offset 14 register unwritten", reg_bank[14*8 +: 8], 8'h00);
        for (int k = 0; k < 4; k++) buf_read_byte("R7 buffer read", bytes[k]);
        send(8'hDE);
        check("R5 repeated high select holds", host_status, stat_of(bytes[3][7:4]));
        send(8'hEE);
        send(8'hCE);
        check("R7 pointer restarts from idle", host_status, stat_of(bytes[0][3:0]));
        send(8'hC3);
        check("R4 read leaves buffer", host_status, stat_of(exp_reg[3][3:0]));
        send(8'hDE);
        check("R7 high select entry from register read", host_status, stat_of(bytes[0][7:4]));
        send(8'hEE);
    endtask

    task automatic t_wrap;
        logic [7:0] w [DEPTH+2];
        for (int k = 0; k < DEPTH + 2; k++) w[k] = 8'(8'h31 + k * 8'h17);
        send(8'hEE);
        send(8'h4E);
        for (int k = 0; k < DEPTH + 2; k++) buf_write_byte(w[k]);
        send(8'hEE);
        for (int k = 0; k < DEPTH; k++)
            buf_read_byte("R10 wrapped write", (k < 2) ? w[DEPTH + k] : w[k]);
        buf_read_byte("R10 read pointer wraps", w[DEPTH]);
        send(8'hEE);
        check("R2 end after wrap", host_status, 8'h00);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < REG_CNT; k++) exp_reg[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_write();
        t_reg_read();
        t_ignore();
        t_buffer();
        t_wrap();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule